// File: doc/BRIEF.md
# Prioritized CPU Halt Controller

This block decides when a processor core must stop for debug and when it may run again. It takes three kinds of stop request. A double-fault indication stops the core at once. Breakpoint requests, from any of several hardware comparators or from an external breakpoint pin, are first held in a sticky pending store and are honoured only at an instruction-boundary sample strobe. A decoded HALT instruction stops the core at once if the current mode allows it.

When several requests meet in one cycle, a fixed priority picks the winner. The double fault wins over a pending breakpoint, and a pending breakpoint wins over the HALT instruction. A HALT issued in user mode while the user-halt enable is clear does not stop the core. It raises a one-cycle privilege-violation request instead.

While the core is stopped, a GO strobe from the debug serial side restarts it. The block gives one resume pulse and a select bit. The select bit says whether execution continues at the instruction after a HALT, or at the address the pipeline already holds.

Top module: `halt_ctrl`

## Requirements
- R1: After reset `halted_o`=0, `halt_cause_o`=2'b00, `priv_viol_o`=0, `resume_o`=0 and `resume_sel_o`=0.
- R2: While running, `fof_i`=1 sets `halted_o`=1 on the next clock edge with `halt_cause_o`=2'b01, whatever the boundary strobe and the other requests are doing.
- R3: A breakpoint request (any bit of `hwbp_req_i` or `brk_pin_i`) made while running is held as pending without stopping the core. It persists until a boundary strobe arrives, and while no strobe arrives `halted_o` stays 0.
- R4: A pending breakpoint is taken at the first `insn_boundary_i`=1, counted from the cycle after the request. The core halts on the next edge with `halt_cause_o`=2'b10. Every halt clears the pending store.
- R5: `halt_insn_i`=1 with `user_mode_i`=0, or with `user_halt_en_i`=1, halts the core on the next edge with `halt_cause_o`=2'b11.
- R6: `halt_insn_i`=1 with `user_mode_i`=1 and `user_halt_en_i`=0 does not halt the core. If no other source halts it in that cycle, `priv_viol_o` is 1 for exactly the next cycle.
- R7: Sources that meet in one cycle are resolved as fault over pending breakpoint over HALT instruction. A HALT instruction that loses raises no privilege violation.
- R8: GO while halted clears `halted_o` and `halt_cause_o` on the next edge. It pulses `resume_o` for one cycle, with `resume_sel_o`=1 exactly when the halt cause was 2'b11 (continue after the HALT).
- R9: GO while running has no effect: no resume pulse, and `halted_o` and the pending store are unchanged.
- R10: While halted, fault, breakpoint and HALT-instruction inputs are ignored. The cause is unchanged, and no breakpoint becomes pending for after the resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fof_i | input | 1 | Double-fault indication |
| hwbp_req_i | input | HWBP_N | Hardware breakpoint comparator requests |
| brk_pin_i | input | 1 | External breakpoint pin request |
| insn_boundary_i | input | 1 | Instruction-boundary sample strobe |
| halt_insn_i | input | 1 | Decoded HALT instruction strobe |
| user_mode_i | input | 1 | 1 = core in user mode |
| user_halt_en_i | input | 1 | Permits HALT in user mode |
| go_i | input | 1 | GO command strobe |
| halted_o | output | 1 | Core is halted |
| halt_cause_o | output | 2 | 00 none, 01 fault, 10 breakpoint, 11 HALT instruction |
| priv_viol_o | output | 1 | One-cycle privilege-violation request |
| resume_o | output | 1 | One-cycle resume request |
| resume_sel_o | output | 1 | With resume: 1 = next instruction after HALT |

## Verification
The bench sweeps all 64 combinations of fault, prior pending breakpoint, boundary strobe, HALT strobe, mode and enable, all applied in one cycle. It checks the winning cause and the privilege-violation decision against a priority model computed in the bench. The sharpest overlap is a user-mode HALT that is refused while a fault or a pending breakpoint halts in the same cycle. Here the privilege-violation pulse must not appear. A second overlap puts GO in the same cycle as stop requests while halted. There the resume must win, and no breakpoint may be carried past it.

// File: rtl/halt_pkg.sv
package halt_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_FAULT = 2'b01,
        CAUSE_BRKPT = 2'b10,
        CAUSE_HALTI = 2'b11
    } halt_cause_e;

    typedef struct packed {
        logic fault;
        logic brk_due;
        logic instr_ok;
        logic instr_bad;
    } halt_req_t;

    function automatic logic instr_permitted(input logic user, input logic uhe);
        return !user || uhe;
    endfunction

    function automatic halt_cause_e pick_cause(input halt_req_t r);
        if (r.fault)         return CAUSE_FAULT;
        else if (r.brk_due)  return CAUSE_BRKPT;
        else if (r.instr_ok) return CAUSE_HALTI;
        else                 return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/hc_brk_pending.sv
module hc_brk_pending #(
    parameter int HWBP_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HWBP_N-1:0] hwbp_req,
    input  logic              pin_req,
    input  logic              halted,
    input  logic              take,
    output logic              pending
);
    localparam int SRC_N = HWBP_N + 1;

    logic [SRC_N-1:0] src_req;
    logic [SRC_N-1:0] sticky_q;

    assign src_req = {pin_req, hwbp_req};

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst || take) begin
                sticky_q[i] <= 1'b0;
            end else if (!halted && src_req[i]) begin
                sticky_q[i] <= 1'b1;
            end
        end
    end

    assign pending = |sticky_q;

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        pending && !take |=> pending);                                   // R3
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        take |=> !pending);                                              // R4
    AST_PEND_NO_SET_HALTED: assert property (@(posedge clk) disable iff (rst)
        halted && !pending |=> !pending);                                // R10
endmodule

// File: rtl/hc_arbiter.sv
module hc_arbiter
    import halt_pkg::*;
(
    input  logic        fault,
    input  logic        pending,
    input  logic        boundary,
    input  logic        halt_insn,
    input  logic        user_mode,
    input  logic        user_halt_en,
    input  logic        halted,
    output halt_cause_e cause_next,
    output logic        take,
    output logic        priv_req
);
    halt_req_t   req;
    halt_cause_e winner;
    logic        permit;

    always_comb begin
        permit        = instr_permitted(user_mode, user_halt_en);
        req.fault     = fault;
        req.brk_due   = pending && boundary;
        req.instr_ok  = halt_insn && permit;
        req.instr_bad = halt_insn && !permit;
        winner        = pick_cause(req);
        take          = !halted && (winner != CAUSE_NONE);
        cause_next    = take ? winner : CAUSE_NONE;
        priv_req      = !halted && req.instr_bad && (winner == CAUSE_NONE);
    end
endmodule

// File: rtl/hc_run_state.sv
module hc_run_state
    import halt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  halt_cause_e cause_next,
    input  logic        priv_req,
    input  logic        go,
    output logic        halted,
    output halt_cause_e cause,
    output logic        priv_viol,
    output logic        resume,
    output logic        resume_sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            halted     <= 1'b0;
            cause      <= CAUSE_NONE;
            priv_viol  <= 1'b0;
            resume     <= 1'b0;
            resume_sel <= 1'b0;
        end else begin
            priv_viol  <= 1'b0;
            resume     <= 1'b0;
            resume_sel <= 1'b0;
            if (halted) begin
                if (go) begin
                    halted     <= 1'b0;
                    cause      <= CAUSE_NONE;
                    resume     <= 1'b1;
                    resume_sel <= (cause == CAUSE_HALTI);
                end
            end else if (take) begin
                halted <= 1'b1;
                cause  <= cause_next;
            end else begin
                priv_viol <= priv_req;
            end
        end
    end

    AST_RESUME_ONLY_FROM_HALT: assert property (@(posedge clk) disable iff (rst)
        !halted && !resume |=> !resume);                                 // R9
    AST_GO_RELEASES: assert property (@(posedge clk) disable iff (rst)
        halted && go |=> !halted && resume);                             // R8
    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
        halted && !go |=> halted && $stable(cause));                     // R10
    AST_RUN_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !halted |-> cause == CAUSE_NONE);                                // R8
endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl
    import halt_pkg::*;
#(
    parameter int HWBP_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fof_i,
    input  logic [HWBP_N-1:0] hwbp_req_i,
    input  logic              brk_pin_i,
    input  logic              insn_boundary_i,
    input  logic              halt_insn_i,
    input  logic              user_mode_i,
    input  logic              user_halt_en_i,
    input  logic              go_i,
    output logic              halted_o,
    output logic [1:0]        halt_cause_o,
    output logic              priv_viol_o,
    output logic              resume_o,
    output logic              resume_sel_o
);
    logic        pending;
    logic        take;
    logic        priv_req;
    halt_cause_e cause_next;
    halt_cause_e cause_q;

    hc_brk_pending #(.HWBP_N(HWBP_N)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .hwbp_req (hwbp_req_i),
        .pin_req  (brk_pin_i),
        .halted   (halted_o),
        .take     (take),
        .pending  (pending)
    );

    hc_arbiter u_arb (
        .fault        (fof_i),
        .pending      (pending),
        .boundary     (insn_boundary_i),
        .halt_insn    (halt_insn_i),
        .user_mode    (user_mode_i),
        .user_halt_en (user_halt_en_i),
        .halted       (halted_o),
        .cause_next   (cause_next),
        .take         (take),
        .priv_req     (priv_req)
    );

    hc_run_state u_state (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .cause_next (cause_next),
        .priv_req   (priv_req),
        .go         (go_i),
        .halted     (halted_o),
        .cause      (cause_q),
        .priv_viol  (priv_viol_o),
        .resume     (resume_o),
        .resume_sel (resume_sel_o)
    );

    assign halt_cause_o = cause_q;

    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (rst)
        !halted_o && fof_i |=> halted_o && halt_cause_o == 2'b01);       // R2
    AST_BRK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !halted_o && !fof_i && pending && insn_boundary_i
        |=> halted_o && halt_cause_o == 2'b10);                          // R4
    AST_NO_STOP_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !halted_o && !fof_i && !insn_boundary_i && !halt_insn_i |=> !halted_o); // R3
    AST_HALT_PERMITTED: assert property (@(posedge clk) disable iff (rst)
        !halted_o && !fof_i && !(pending && insn_boundary_i) && halt_insn_i
        && (!user_mode_i || user_halt_en_i) |=> halted_o && halt_cause_o == 2'b11); // R5
    AST_PRIV_REFUSED: assert property (@(posedge clk) disable iff (rst)
        !halted_o && !fof_i && !(pending && insn_boundary_i) && halt_insn_i
        && user_mode_i && !user_halt_en_i |=> priv_viol_o && !halted_o); // R6
    AST_PRIV_ONLY_WHEN_UNUSED: assert property (@(posedge clk) disable iff (rst)
        priv_viol_o |-> !halted_o);                                      // R7
endmodule

// File: tb/halt_ctrl_bench.sv
module halt_ctrl_bench;
    localparam int HWBP_N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fof = 0, pin = 0, bnd = 0, hi = 0, usr = 0, uhe = 0, go = 0;
    logic [HWBP_N-1:0] hw = '0;
    logic halted, priv, resume, rsel;
    logic [1:0] cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    halt_ctrl #(.HWBP_N(HWBP_N)) u_halt_ctrl (
        .clk(clk), .rst(rst), .fof_i(fof), .hwbp_req_i(hw), .brk_pin_i(pin),
        .insn_boundary_i(bnd), .halt_insn_i(hi), .user_mode_i(usr),
        .user_halt_en_i(uhe), .go_i(go), .halted_o(halted),
        .halt_cause_o(cause), .priv_viol_o(priv), .resume_o(resume),
        .resume_sel_o(rsel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        fof = 0; pin = 0; bnd = 0; hi = 0; go = 0; hw = '0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        cyc();
        cyc();
        rst = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 halted", halted, 0);
        chk("R1 cause", cause, 0);
        chk("R1 priv", priv, 0);
        chk("R1 resume", resume, 0);
        chk("R1 sel", rsel, 0);

        for (int idx = 0; idx < 64; idx++) begin
            automatic logic e_fof = idx[0];
            automatic logic e_pnd = idx[1];
            automatic logic e_bnd = idx[2];
            automatic logic e_hi  = idx[3];
            automatic logic e_usr = idx[4];
            automatic logic e_uhe = idx[5];
            automatic logic ok = e_hi && (!e_usr || e_uhe);
            automatic int exp_c = e_fof ? 1 : (e_pnd && e_bnd) ? 2 : ok ? 3 : 0;
            automatic int exp_p = (e_hi && !ok && exp_c == 0) ? 1 : 0;
            do_reset();
            usr = e_usr; uhe = e_uhe;
            if (e_pnd) begin
                if (idx[5]) pin = 1;
                else hw[idx % HWBP_N] = 1;
                cyc();
                chk("R3 request alone no halt", halted, 0);
                idle();
            end
            fof = e_fof; bnd = e_bnd; hi = e_hi;
            cyc();
            chk("R2/R4/R5/R7 halted", halted, exp_c != 0);
            chk("R2/R4/R5/R7 cause", cause, exp_c);
            chk("R6/R7 priv", priv, exp_p);
            idle();
            cyc();
            chk("R6 priv one cycle", priv, 0);
            chk("R5 halt held", halted, exp_c != 0);
            if (exp_c != 0) begin
                go = 1;
                cyc();
                chk("R8 released", halted, 0);
                chk("R8 resume", resume, 1);
                chk("R8 sel", rsel, exp_c == 3);
                chk("R8 cause cleared", cause, 0);
                idle();
                cyc();
                chk("R8 resume one cycle", resume, 0);
                bnd = 1;
                cyc();
                chk("R4 pending cleared by halt", halted, 0);
                idle();
            end else begin
                go = 1;
                cyc();
                chk("R9 no resume", resume, 0);
                chk("R9 still running", halted, 0);
                idle();
                bnd = 1;
                cyc();
                chk("R3 pending kept", halted, e_pnd);
                chk("R3 cause", cause, e_pnd ? 2 : 0);
                idle();
            end
        end

        // R10 inputs ignored while halted
        do_reset();
        usr = 0; uhe = 0; hi = 1;
        cyc();
        chk("R5 supervisor halt", cause, 3);
        idle();
        fof = 1; pin = 1; hw = '1; hi = 1; bnd = 1;
        cyc();
        chk("R10 cause kept", cause, 3);
        chk("R10 no priv", priv, 0);
        idle();
        go = 1; pin = 1; bnd = 1;
        cyc();
        chk("R8 resume over requests", resume, 1);
        chk("R10 sel from original cause", rsel, 1);
        idle();
        bnd = 1;
        cyc();
        chk("R10 no carried breakpoint", halted, 0);
        idle();

        // R9 GO does not disturb a pending breakpoint
        hw[0] = 1;
        cyc();
        idle();
        go = 1;
        cyc();
        chk("R9 go running", resume, 0);
        idle();
        bnd = 1;
        cyc();
        chk("R9 pending survives go", cause, 2);
        idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule